// File: doc/BRIEF.md
# Debug Port Control-Register Read Handler

This block is the target-side handler for one debug command: reading a single processor control register over a word-serial debug link. A bit-level shifter outside the block delivers 16-bit words, one exchange at a time. For every word it delivers, the handler loads the 17-bit word that the shifter sends back. That word is a status bit followed by 16 data bits.

When the handler sees the read opcode, it collects a 32-bit register select in two words, high word first. It then issues the read on a level request / pulse acknowledge register port. Until the result is held, every exchange is answered with a not-ready code. The value then comes back high word first. Register bits a narrow register does not implement are returned as zero. A faulted access is answered with a bus-error code in place of the result.

The exchange that carries the final answer also carries the host's next command, so commands can follow one another with no idle slot. An unknown opcode earns an illegal-command code and starts no access. A zero word is a no-operation.

Top module: `crd_read_handler`

## Requirements
- R1: After a synchronous active-high reset, tx_status is 1, tx_data is 0x0000 and reg_req is 0. The outputs change only on a clock edge where rx_valid is 1.
- R2: The read opcode (default 0xC3A0), received while idle, is answered with not-ready. The next two words form reg_sel, high word first. reg_req rises on the edge that takes the second of them.
- R3: Every word taken while the select is being collected, or while reg_req is high, is answered with tx_status 1 and tx_data 0x0000 (not-ready).
- R4: Once the read has been acknowledged without error, the next exchange returns tx_status 0 with bits 31:16 of the value, and the following exchange returns tx_status 0 with bits 15:0. The word received with the high half is ignored.
- R5: Select 0x0000080E is a 16-bit register and select 0x00000C04 is an 8-bit register. For these two, the returned bits above the implemented width are zero. Every other select returns all 32 bits.
- R6: An access acknowledged with reg_err 1 is answered in the next exchange with tx_status 1 and tx_data 0x0001, and no low-word exchange follows. The word received in that exchange is decoded as a new command.
- R7: The word received in the exchange that returns the low result half is decoded as a new command.
- R8: While idle, a word that is neither the read opcode nor 0x0000 is answered with tx_status 1 and tx_data 0x0002 (illegal), and no access starts. The word 0x0000 is answered with not-ready and leaves the handler idle.
- R9: An unknown opcode received in an overlapped slot (the bus-error or low-half exchange) is answered with the illegal code in the following exchange. The word received in that following exchange is decoded as a command.
- R10: A word and an acknowledge arriving on the same edge: the word is answered with not-ready, the value is captured, and the next exchange returns the high half.
- R11: reg_req stays high with a stable reg_sel until reg_ack, and falls on the edge after it. reg_ack while no access is pending has no effect.
- R12: Reset during a pending access drops reg_req. A later acknowledge is ignored, and the handler is idle.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a word exchange takes place |
| rx_word | input | 16 | Word received from the debug shifter |
| tx_status | output | 1 | Status bit of the returned word (0 = data) |
| tx_data | output | 16 | Data bits of the returned word |
| reg_req | output | 1 | Register read request, held until acknowledged |
| reg_sel | output | 32 | Control-register select for the read |
| reg_ack | input | 1 | One-cycle acknowledge of the read |
| reg_err | input | 1 | Qualifies reg_ack: the access faulted |
| reg_rdata | input | 32 | Read value, valid with reg_ack |

## Verification
Two functions can collide on one edge. The first is capture of the register-port acknowledge; the second is an incoming word exchange. The bench provokes this by raising reg_ack and rx_valid in the same cycle. It then judges that the word is answered not-ready and that the very next exchange returns the captured high half. A second collision pairs result delivery with command decode. The bench places the read opcode, an unknown opcode, or a no-operation in the low-half and bus-error slots. It checks both the answer in that slot and what the following exchanges return.

// File: rtl/crd_pkg.sv
package crd_pkg;
  localparam int WORD_W = 16;
  localparam int SEL_W  = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL_HI,
    ST_SEL_LO,
    ST_WAIT,
    ST_READY,
    ST_RES_LO,
    ST_ILL
  } crd_state_e;

  localparam logic [WORD_W-1:0] CODE_NOT_READY = 16'h0000;
  localparam logic [WORD_W-1:0] CODE_BUS_ERR   = 16'h0001;
  localparam logic [WORD_W-1:0] CODE_ILLEGAL   = 16'h0002;
endpackage

// File: rtl/crd_cmd_decode.sv
module crd_cmd_decode #(
  parameter int          WORD_W  = 16,
  parameter logic [15:0] OPC_READ = 16'hC3A0,
  parameter logic [15:0] OPC_NOP  = 16'h0000
) (
  input  logic [WORD_W-1:0] word,
  output logic              is_read,
  output logic              is_nop
);
  always_comb begin
    is_read = (word == OPC_READ[WORD_W-1:0]);
    is_nop  = (word == OPC_NOP[WORD_W-1:0]);
  end
endmodule

// File: rtl/crd_narrow_mask.sv
module crd_narrow_mask #(
  parameter int                   SEL_W    = 32,
  parameter int                   N_NARROW = 2,
  parameter int                   WID_W    = 6,
  parameter logic [N_NARROW*SEL_W-1:0] NARROW_SELS = {32'h0000_0C04, 32'h0000_080E},
  parameter logic [N_NARROW*WID_W-1:0] NARROW_WIDS = {6'd8, 6'd16}
) (
  input  logic [SEL_W-1:0] sel,
  output logic [SEL_W-1:0] mask
);
  logic [N_NARROW-1:0]   hit;
  logic [SEL_W-1:0]      part [N_NARROW];

  for (genvar i = 0; i < N_NARROW; i++) begin : g_narrow
    localparam logic [SEL_W:0] ONES = (({{SEL_W{1'b0}}, 1'b1}) << NARROW_WIDS[i*WID_W +: WID_W]) - 1'b1;
    assign hit[i]  = (sel == NARROW_SELS[i*SEL_W +: SEL_W]);
    assign part[i] = hit[i] ? ONES[SEL_W-1:0] : '0;
  end

  always_comb begin
    mask = '0;
    for (int i = 0; i < N_NARROW; i++) mask = mask | part[i];
    if (hit == '0) mask = '1;
  end
endmodule

// File: rtl/crd_capture.sv
module crd_capture #(
  parameter int SEL_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [SEL_W-1:0] rdata,
  input  logic             err,
  input  logic [SEL_W-1:0] mask,
  output logic [SEL_W-1:0] value,
  output logic             faulted
);
  always_ff @(posedge clk) begin
    if (rst) begin
      value   <= '0;
      faulted <= 1'b0;
    end else if (cap_en) begin
      value   <= rdata & mask;
      faulted <= err;
    end
  end
endmodule

// File: rtl/crd_read_handler.sv
module crd_read_handler
  import crd_pkg::*;
#(
  parameter logic [15:0] OPC_READ = 16'hC3A0,
  parameter logic [15:0] OPC_NOP  = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  output logic              tx_status,
  output logic [WORD_W-1:0] tx_data,
  output logic              reg_req,
  output logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_ack,
  input  logic              reg_err,
  input  logic [SEL_W-1:0]  reg_rdata
);
  localparam int HALF = SEL_W / 2;

  crd_state_e        state;
  logic [WORD_W-1:0] sel_hi;
  logic              is_read, is_nop;
  logic [SEL_W-1:0]  mask, value;
  logic              faulted, cap_en;
  crd_state_e        cmd_next;

  crd_cmd_decode #(.WORD_W(WORD_W), .OPC_READ(OPC_READ), .OPC_NOP(OPC_NOP)) u_dec (
    .word(rx_word), .is_read(is_read), .is_nop(is_nop));

  crd_narrow_mask #(.SEL_W(SEL_W)) u_mask (.sel(reg_sel), .mask(mask));

  assign cap_en = (state == ST_WAIT) && reg_ack;

  crd_capture #(.SEL_W(SEL_W)) u_cap (
    .clk(clk), .rst(rst), .cap_en(cap_en), .rdata(reg_rdata), .err(reg_err),
    .mask(mask), .value(value), .faulted(faulted));

  // State after a word decoded in a slot whose answer is already taken.
  always_comb begin
    if (is_read)     cmd_next = ST_SEL_HI;
    else if (is_nop) cmd_next = ST_IDLE;
    else             cmd_next = ST_ILL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tx_status <= 1'b1;
      tx_data   <= CODE_NOT_READY;
      reg_req   <= 1'b0;
      reg_sel   <= '0;
      sel_hi    <= '0;
    end else begin
      if (cap_en) begin
        reg_req <= 1'b0;
        state   <= ST_READY;
      end
      if (rx_valid) begin
        case (state)
          ST_IDLE, ST_ILL: begin
            tx_status <= 1'b1;
            if (state == ST_ILL)          tx_data <= CODE_ILLEGAL;
            else if (is_read || is_nop)   tx_data <= CODE_NOT_READY;
            else                          tx_data <= CODE_ILLEGAL;
            if (state == ST_ILL)          state <= cmd_next;
            else                          state <= is_read ? ST_SEL_HI : ST_IDLE;
          end
          ST_SEL_HI: begin
            sel_hi    <= rx_word;
            tx_status <= 1'b1;
            tx_data   <= CODE_NOT_READY;
            state     <= ST_SEL_LO;
          end
          ST_SEL_LO: begin
            reg_sel   <= {sel_hi, rx_word};
            reg_req   <= 1'b1;
            tx_status <= 1'b1;
            tx_data   <= CODE_NOT_READY;
            state     <= ST_WAIT;
          end
          ST_WAIT: begin
            tx_status <= 1'b1;
            tx_data   <= CODE_NOT_READY;
          end
          ST_READY: begin
            if (faulted) begin
              tx_status <= 1'b1;
              tx_data   <= CODE_BUS_ERR;
              state     <= cmd_next;
            end else begin
              tx_status <= 1'b0;
              tx_data   <= value[SEL_W-1:HALF];
              state     <= ST_RES_LO;
            end
          end
          ST_RES_LO: begin
            tx_status <= 1'b0;
            tx_data   <= value[HALF-1:0];
            state     <= cmd_next;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/crd_read_handler_chk.sv
module crd_read_handler_chk (
  input logic        clk,
  input logic        rst,
  input logic        rx_valid,
  input logic        tx_status,
  input logic [15:0] tx_data,
  input logic        reg_req,
  input logic [31:0] reg_sel,
  input logic        reg_ack
);
  a_r1_tx_hold: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> $stable({tx_status, tx_data}));

  a_r3_not_ready_pending: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && reg_req) |=> (tx_status && tx_data == 16'h0000));

  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_sel)));

  a_r11_req_drop: assert property (@(posedge clk) disable iff (rst)
    (reg_req && reg_ack) |=> !reg_req);

  a_r2_req_on_word: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_req) |-> $past(rx_valid));

  a_r6_status_codes: assert property (@(posedge clk) disable iff (rst)
    tx_status |-> (tx_data <= 16'h0002));
endmodule

bind crd_read_handler crd_read_handler_chk u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .tx_status(tx_status),
  .tx_data(tx_data), .reg_req(reg_req), .reg_sel(reg_sel), .reg_ack(reg_ack));

// File: tb/sim_crd_read_handler.sv
`timescale 1ns/1ps
module sim_crd_read_handler;
  localparam logic [15:0] OPC = 16'hC3A0;
  localparam logic [15:0] NOP = 16'h0000;
  localparam logic [15:0] BAD = 16'h5555;
  localparam int NV = 5;
  localparam logic [31:0] T_SEL [NV] = '{32'h0000_080E, 32'h0000_0C04, 32'h0000_0801, 32'hFFFF_0002, 32'h0000_0C0F};
  localparam logic [31:0] T_DAT [NV] = '{32'hDEAD_BEEF, 32'h1234_5678, 32'hCAFE_F00D, 32'h0BAD_0BAD, 32'h8000_0001};
  localparam logic        T_ERR [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [31:0] T_EXP [NV] = '{32'h0000_BEEF, 32'h0000_0078, 32'hCAFE_F00D, 32'h0, 32'h8000_0001};

  logic clk = 0, rst = 1, rx_valid = 0, reg_ack = 0, reg_err = 0;
  logic [15:0] rx_word = 0;
  logic [31:0] reg_rdata = 0;
  logic tx_status, reg_req;
  logic [15:0] tx_data;
  logic [31:0] reg_sel;
  int checks = 0, fails = 0;
  logic [16:0] r;

  always #2 clk = ~clk;

  crd_read_handler u0 (.clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_word(rx_word),
    .tx_status(tx_status), .tx_data(tx_data), .reg_req(reg_req), .reg_sel(reg_sel),
    .reg_ack(reg_ack), .reg_err(reg_err), .reg_rdata(reg_rdata));

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xchg(input logic [15:0] w, output logic [16:0] resp);
    @(negedge clk); rx_valid = 1; rx_word = w;
    @(negedge clk); rx_valid = 0; resp = {tx_status, tx_data};
  endtask

  task automatic ack(input logic [31:0] d, input logic e);
    @(negedge clk); reg_ack = 1; reg_rdata = d; reg_err = e;
    @(negedge clk); reg_ack = 0; reg_err = 0;
  endtask

  task automatic start(input logic [31:0] s);
    xchg(OPC, r);          chk("R2 opcode not-ready", {16'h0, r}, {16'h0, 17'h10000});
    xchg(s[31:16], r);     chk("R3 sel hi not-ready", {16'h0, r}, {16'h0, 17'h10000});
    xchg(s[15:0], r);      chk("R3 sel lo not-ready", {16'h0, r}, {16'h0, 17'h10000});
    chk("R2 req and select", {reg_req, reg_sel}, {1'b1, s});
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset state", {16'h0, tx_status, tx_data, reg_req}, {16'h0, 1'b1, 16'h0, 1'b0});
    repeat (3) @(negedge clk);
    chk("R1 outputs hold without exchange", {16'h0, tx_status, tx_data}, {16'h0, 17'h10000});

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      start(T_SEL[i]);
      repeat (2) @(negedge clk);
      xchg(16'h1234, r); chk("R3 not-ready while pending", {16'h0, r}, {16'h0, 17'h10000});
      chk("R11 req held", {32'h0, reg_req}, 33'h1);
      ack(T_DAT[i], T_ERR[i]);
      chk("R11 req dropped", {32'h0, reg_req}, 33'h0);
      if (T_ERR[i]) begin
        xchg(NOP, r); chk("R6 bus error code", {16'h0, r}, {16'h0, 17'h10001});
      end else begin
        xchg(16'hAAAA, r); chk("R4 R5 high half", {16'h0, r}, {16'h0, 1'b0, T_EXP[i][31:16]});
        xchg(NOP, r);      chk("R4 R5 low half", {16'h0, r}, {16'h0, 1'b0, T_EXP[i][15:0]});
      end
      xchg(NOP, r); chk("R8 idle nop", {16'h0, r}, {16'h0, 17'h10000});
    end

    // R8 illegal opcode in idle
    xchg(BAD, r); chk("R8 illegal in idle", {16'h0, r}, {16'h0, 17'h10002});
    chk("R8 no access", {32'h0, reg_req}, 33'h0);
    xchg(NOP, r); chk("R8 stays idle", {16'h0, r}, {16'h0, 17'h10000});

    // R11 ack while idle has no effect
    ack(32'h1111_2222, 1'b0);
    xchg(NOP, r); chk("R11 stray ack ignored", {16'h0, r}, {16'h0, 17'h10000});

    // R10 word and ack on the same edge, then R7 opcode in the low slot
    start(32'h0000_0801);
    @(negedge clk); rx_valid = 1; rx_word = 16'h7777; reg_ack = 1; reg_rdata = 32'hA5A5_5A5A;
    @(negedge clk); rx_valid = 0; reg_ack = 0;
    chk("R10 collision answered not-ready", {16'h0, tx_status, tx_data}, {16'h0, 17'h10000});
    xchg(NOP, r); chk("R10 high half next", {16'h0, r}, {16'h0, 17'h0A5A5});
    xchg(OPC, r); chk("R7 low half with opcode", {16'h0, r}, {16'h0, 17'h05A5A});
    xchg(16'h0000, r); chk("R7 sel hi", {16'h0, r}, {16'h0, 17'h10000});
    xchg(16'h0C04, r); chk("R7 access started", {reg_req, reg_sel}, {1'b1, 32'h0000_0C04});

    // R6 opcode in bus-error slot starts the next command
    ack(32'h0, 1'b1);
    xchg(OPC, r); chk("R6 bus error with opcode", {16'h0, r}, {16'h0, 17'h10001});
    xchg(16'h0000, r);
    xchg(16'h080E, r); chk("R6 next access started", {reg_req, reg_sel}, {1'b1, 32'h0000_080E});
    ack(32'h0000_4321, 1'b0);
    xchg(NOP, r); chk("R4 high half", {16'h0, r}, {16'h0, 17'h00000});

    // R9 unknown opcode in the low slot
    xchg(BAD, r); chk("R9 low half", {16'h0, r}, {16'h0, 17'h04321});
    xchg(NOP, r); chk("R9 illegal answered later", {16'h0, r}, {16'h0, 17'h10002});
    xchg(NOP, r); chk("R9 idle after", {16'h0, r}, {16'h0, 17'h10000});

    // R12 reset during a pending access
    start(32'h0000_0801);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R12 req dropped by reset", {32'h0, reg_req}, 33'h0);
    ack(32'hFFFF_FFFF, 1'b0);
    xchg(NOP, r); chk("R12 idle after reset", {16'h0, r}, {16'h0, 17'h10000});
    chk("R12 no request", {32'h0, reg_req}, 33'h0);

    finish_run();
  end
endmodule